// File: doc/BRIEF.md
# Threshold-Hysteresis RTS/CTS Flow Controller

This block gives one serial channel automatic request-to-send / clear-to-send handling. On the receive side it compares the fill count of the receive FIFO against two programmable levels. It drops the request line once the FIFO is nearly full. It raises the line again only after the FIFO has drained far enough, so the far end is not toggled on every byte.

On the transmit side it synchronises the incoming clear line and produces a permit that the transmitter consults before it starts each character. The permit is refreshed only while the transmitter reports that it is between characters. A character that is already on the wire is therefore always completed. Any edge on the synchronised clear line also latches a sticky change event, which a read strobe clears.

The two directions have independent enables. Both lines are active-low at the pins. The halt and resume levels are taken from one 8-bit threshold word:

- The low nibble sets the halt level.
- The high nibble sets the resume level.
- Each nibble counts in units of four bytes.

Top module: `hfc_top`

## Requirements
- R1: After reset `rts_n` is 1, `tx_permit` is 0 and `cts_changed` is 0, and both stored thresholds are 0. With auto-RTS on and unchanged thresholds, a halt level of 0 keeps `rts_n` at 1.
- R2: A cycle with `thr_we`=1 stores `thr_wdata`, which then governs `rts_n` from the second clock edge on. The halt level is `thr_wdata[3:0]`×4 and the resume level is `thr_wdata[7:4]`×4.
- R3: While `auto_rts_en` is 0, `rts_n` is 1 one cycle later, whatever `rx_level` holds.
- R4: With auto-RTS on, an `rx_level` at or above the halt level drives `rts_n` to 1 one cycle later. This holds even when `rx_level` is also at or below the resume level.
- R5: With auto-RTS on, an `rx_level` below the halt level and at or below the resume level drives `rts_n` to 0 one cycle later.
- R6: With auto-RTS on, an `rx_level` strictly between the resume and halt levels leaves `rts_n` unchanged (hysteresis).
- R7: With auto-CTS on and `tx_bnd`=1, `tx_permit` becomes 1 when `cts_n` is low and 0 when `cts_n` is high. It follows the pin three clock edges after the pin changes: two synchroniser stages and the permit register.
- R8: While `tx_bnd` is 0, `tx_permit` holds its value, so a clear line that drops mid-character does not stop that character.
- R9: With auto-CTS off, `tx_permit` becomes 1 at the next edge where `tx_bnd` is 1, regardless of `cts_n`.
- R10: Each edge of `cts_n` sets `cts_changed` three clock edges later. The flag stays set until a cycle with `cts_chg_clr`=1, after which it is 0. A new edge landing in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_we | input | 1 | Load strobe for the threshold word |
| thr_wdata | input | 8 | Threshold word: [3:0] halt nibble, [7:4] resume nibble |
| auto_rts_en | input | 1 | Enable automatic request line control |
| auto_cts_en | input | 1 | Enable clear-line gating of the transmitter |
| rx_level | input | 7 | Receive FIFO fill count, 0 to 64 |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_bnd | input | 1 | High while the transmitter sits between characters |
| cts_chg_clr | input | 1 | Read strobe that clears the change event |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_permit | output | 1 | Transmitter may start the next character |
| cts_changed | output | 1 | Sticky clear-line change event |

## Verification
The request output is due one cycle after an `rx_level` or enable change and two cycles after a threshold load. The permit and the change event are due three cycles after a `cts_n` edge, and the permit is due one cycle after an enable or boundary change while the clear line is already settled.

The bench drives every input on a falling edge and counts exactly those rising edges before sampling on a later falling edge. The clear-line cases also sample one cycle early, to show that nothing appears before the synchroniser delay. The threshold sweep ramps the level fully up and down for every legal halt/resume pair and predicts each cycle's output from the arithmetic rules alone.

// File: rtl/hfc_pkg.sv
package hfc_pkg;

    // Fill count width: must hold the full FIFO depth (64 -> 7 bits)
    parameter int LVL_W   = 7;
    // Width of one threshold field
    parameter int NIB_W   = 4;
    // Threshold granularity as a shift (4 bytes per step)
    parameter int STEP_SH = 2;
    // Clear-line synchroniser depth
    parameter int SYNC_N  = 2;

    localparam int THR_W  = 2 * NIB_W;

    // Upper field is the resume level, lower field the halt level
    typedef struct packed {
        logic [NIB_W-1:0] resume;
        logic [NIB_W-1:0] halt;
    } thr_t;

    typedef enum logic {
        FLOW_GO   = 1'b0,
        FLOW_HALT = 1'b1
    } flow_e;

    function automatic logic [LVL_W-1:0] nib_to_level(input logic [NIB_W-1:0] nib);
        return LVL_W'(nib) << STEP_SH;
    endfunction

endpackage

// File: rtl/hfc_thr_reg.sv
module hfc_thr_reg
    import hfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [THR_W-1:0] wdata,
    output thr_t             thr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
        end else if (we) begin
            thr_q <= thr_t'(wdata);
        end
    end

endmodule

// File: rtl/hfc_rts_hyst.sv
module hfc_rts_hyst
    import hfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [LVL_W-1:0] level,
    input  thr_t             thr,
    output logic             rts_n
);

    logic [LVL_W-1:0] halt_lvl;
    logic [LVL_W-1:0] resume_lvl;
    flow_e            state_q;
    flow_e            state_d;

    assign halt_lvl   = nib_to_level(thr.halt);
    assign resume_lvl = nib_to_level(thr.resume);

    // Halt comparison has priority so a misprogrammed pair still settles
    always_comb begin
        if (!en) begin
            state_d = FLOW_GO;
        end else if (level >= halt_lvl) begin
            state_d = FLOW_HALT;
        end else if (level <= resume_lvl) begin
            state_d = FLOW_GO;
        end else begin
            state_d = state_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FLOW_GO;
            rts_n   <= 1'b1;
        end else begin
            state_q <= state_d;
            rts_n   <= !en || (state_d == FLOW_HALT);
        end
    end

endmodule

// File: rtl/hfc_cts_sync.sv
module hfc_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din_n,
    output logic active,
    output logic toggled
);

    logic synced_n;
    logic prev_n;

    generate
        if (STAGES <= 1) begin : g_single
            logic s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= 1'b1;
                else     s_q <= din_n;
            end
            assign synced_n = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] sh_q;
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '1;
                else     sh_q <= {sh_q[STAGES-2:0], din_n};
            end
            assign synced_n = sh_q[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_n <= 1'b1;
        else     prev_n <= synced_n;
    end

    assign active  = !synced_n;
    assign toggled = synced_n ^ prev_n;

endmodule

// File: rtl/hfc_tx_gate.sv
module hfc_tx_gate (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic cts_active,
    input  logic cts_toggled,
    input  logic bnd,
    input  logic chg_clr,
    output logic permit,
    output logic changed
);

    always_ff @(posedge clk) begin
        if (rst) begin
            permit  <= 1'b0;
            changed <= 1'b0;
        end else begin
            if (bnd) begin
                permit <= !en || cts_active;
            end
            if (cts_toggled) begin
                changed <= 1'b1;
            end else if (chg_clr) begin
                changed <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/hfc_top.sv
module hfc_top
    import hfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             cts_n,
    input  logic             tx_bnd,
    input  logic             cts_chg_clr,
    output logic             rts_n,
    output logic             tx_permit,
    output logic             cts_changed
);

    thr_t thr_q;
    logic cts_active;
    logic cts_toggled;

    hfc_thr_reg u_thr (
        .clk   (clk),
        .rst   (rst),
        .we    (thr_we),
        .wdata (thr_wdata),
        .thr_q (thr_q)
    );

    hfc_rts_hyst u_rts (
        .clk   (clk),
        .rst   (rst),
        .en    (auto_rts_en),
        .level (rx_level),
        .thr   (thr_q),
        .rts_n (rts_n)
    );

    hfc_cts_sync #(.STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .din_n   (cts_n),
        .active  (cts_active),
        .toggled (cts_toggled)
    );

    hfc_tx_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .en          (auto_cts_en),
        .cts_active  (cts_active),
        .cts_toggled (cts_toggled),
        .bnd         (tx_bnd),
        .chg_clr     (cts_chg_clr),
        .permit      (tx_permit),
        .changed     (cts_changed)
    );

endmodule

// File: rtl/hfc_top_chk.sv
module hfc_top_chk
    import hfc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             auto_rts_en,
    input logic             auto_cts_en,
    input logic [LVL_W-1:0] rx_level,
    input thr_t             thr_q,
    input logic             rts_n,
    input logic             tx_bnd,
    input logic             tx_permit,
    input logic             cts_changed,
    input logic             cts_chg_clr
);

    logic [LVL_W-1:0] h_lvl;
    logic [LVL_W-1:0] r_lvl;

    assign h_lvl = nib_to_level(thr_q.halt);
    assign r_lvl = nib_to_level(thr_q.resume);

    // R3
    rts_off_chk: assert property (@(posedge clk) disable iff (rst)
        !auto_rts_en |=> rts_n);

    // R4
    rts_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_rts_en && rx_level >= h_lvl) |=> rts_n);

    // R5
    rts_resume_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_rts_en && rx_level < h_lvl && rx_level <= r_lvl) |=> !rts_n);

    // R6
    rts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_rts_en && $past(auto_rts_en) && rx_level > r_lvl && rx_level < h_lvl)
        |=> $stable(rts_n));

    // R8
    permit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_bnd |=> $stable(tx_permit));

    // R9
    permit_free_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_bnd && !auto_cts_en) |=> tx_permit);

    // R10
    change_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (cts_changed && !cts_chg_clr) |=> cts_changed);

endmodule

bind hfc_top hfc_top_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .auto_rts_en (auto_rts_en),
    .auto_cts_en (auto_cts_en),
    .rx_level    (rx_level),
    .thr_q       (thr_q),
    .rts_n       (rts_n),
    .tx_bnd      (tx_bnd),
    .tx_permit   (tx_permit),
    .cts_changed (cts_changed),
    .cts_chg_clr (cts_chg_clr)
);

// File: tb/hfc_top_test.sv
module hfc_top_test;
    import hfc_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             thr_we;
    logic [THR_W-1:0] thr_wdata;
    logic             auto_rts_en;
    logic             auto_cts_en;
    logic [LVL_W-1:0] rx_level;
    logic             cts_n;
    logic             tx_bnd;
    logic             cts_chg_clr;
    logic             rts_n;
    logic             tx_permit;
    logic             cts_changed;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    hfc_top uut (
        .clk         (clk),
        .rst         (rst),
        .thr_we      (thr_we),
        .thr_wdata   (thr_wdata),
        .auto_rts_en (auto_rts_en),
        .auto_cts_en (auto_cts_en),
        .rx_level    (rx_level),
        .cts_n       (cts_n),
        .tx_bnd      (tx_bnd),
        .cts_chg_clr (cts_chg_clr),
        .rts_n       (rts_n),
        .tx_permit   (tx_permit),
        .cts_changed (cts_changed)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_thr(input int halt_nib, input int resume_nib);
        thr_we    = 1'b1;
        thr_wdata = THR_W'((resume_nib << NIB_W) | halt_nib);
        cyc(1);
        thr_we    = 1'b0;
    endtask

    initial begin
        cyc(200000);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; thr_we = 1'b0; thr_wdata = '0;
        auto_rts_en = 1'b0; auto_cts_en = 1'b0;
        rx_level = '0; cts_n = 1'b1; tx_bnd = 1'b0; cts_chg_clr = 1'b0;
        cyc(3);
        rst = 1'b0;

        // R1 reset state
        check("R1 rts_n", int'(rts_n), 1);
        check("R1 tx_permit", int'(tx_permit), 0);
        check("R1 cts_changed", int'(cts_changed), 0);
        // R1 thresholds reset to zero: halt level 0 keeps request off
        auto_rts_en = 1'b1;
        cyc(1);
        check("R1 zero halt level", int'(rts_n), 1);

        // R2 load 16/4 bytes: level 0 then asserts request
        load_thr(4, 1);
        check("R2 before load active", int'(rts_n), 1);
        cyc(1);
        check("R2 after load", int'(rts_n), 0);

        // R3 disabled: request stays off across all levels
        auto_rts_en = 1'b0;
        for (int l = 0; l <= 64; l++) begin
            rx_level = LVL_W'(l);
            cyc(1);
            check("R3 auto-RTS off", int'(rts_n), 1);
        end
        rx_level = '0;
        auto_rts_en = 1'b1;
        cyc(1);

        // R4/R5/R6 sweep over every legal halt/resume pair
        for (int h = 1; h < 16; h++) begin
            for (int r = 0; r < h; r++) begin
                int halted = 0;
                load_thr(h, r);
                rx_level = '0;
                cyc(1);
                check("R2 new pair level 0", int'(rts_n), 0);
                for (int s = 0; s <= 129; s++) begin
                    int l = (s <= 64) ? s : 129 - s;
                    string tag;
                    rx_level = LVL_W'(l);
                    if (l >= 4 * h) begin
                        halted = 1; tag = "R4 halt";
                    end else if (l <= 4 * r) begin
                        halted = 0; tag = "R5 resume";
                    end else begin
                        tag = "R6 hold";
                    end
                    cyc(1);
                    check(tag, int'(rts_n), halted);
                end
            end
        end

        // R4 precedence when halt <= resume (misprogrammed)
        load_thr(2, 5);
        rx_level = LVL_W'(12);
        cyc(2);
        check("R4 halt wins", int'(rts_n), 1);
        rx_level = LVL_W'(7);
        cyc(1);
        check("R5 below both", int'(rts_n), 0);

        // R7 clear line goes active with boundary high
        auto_cts_en = 1'b1;
        tx_bnd = 1'b1;
        cts_n = 1'b0;
        cyc(2);
        check("R7 not before sync", int'(tx_permit), 0);
        check("R10 not before sync", int'(cts_changed), 0);
        cyc(1);
        check("R7 permit on", int'(tx_permit), 1);
        check("R10 edge sets", int'(cts_changed), 1);

        // R10 clear strobe
        cts_chg_clr = 1'b1;
        cyc(1);
        cts_chg_clr = 1'b0;
        check("R10 cleared", int'(cts_changed), 0);

        // R8 mid-character drop keeps permit
        tx_bnd = 1'b0;
        cts_n = 1'b1;
        cyc(5);
        check("R8 held mid-char", int'(tx_permit), 1);
        check("R10 falling edge sets", int'(cts_changed), 1);
        tx_bnd = 1'b1;
        cyc(1);
        check("R7 permit off at boundary", int'(tx_permit), 0);

        // R9 auto-CTS off ignores inactive line
        auto_cts_en = 1'b0;
        cyc(1);
        check("R9 free permit", int'(tx_permit), 1);
        tx_bnd = 1'b0;
        auto_cts_en = 1'b1;
        cyc(3);
        check("R8 enable change mid-char", int'(tx_permit), 1);
        tx_bnd = 1'b1;
        cyc(1);
        check("R7 gated again", int'(tx_permit), 0);

        // R10 set wins over simultaneous clear
        cts_chg_clr = 1'b1;
        cyc(1);
        cts_chg_clr = 1'b0;
        check("R10 pre-clear", int'(cts_changed), 0);
        cts_n = 1'b0;
        cyc(2);
        cts_chg_clr = 1'b1;
        cyc(1);
        cts_chg_clr = 1'b0;
        check("R10 set beats clear", int'(cts_changed), 1);
        check("R7 permit returns", int'(tx_permit), 1);
        cts_chg_clr = 1'b1;
        cyc(1);
        cts_chg_clr = 1'b0;
        check("R10 later clear", int'(cts_changed), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule